// File: doc/BRIEF.md
# Directory-Coherent Cache Block Controller

This block is the cache-side half of a directory coherence scheme. It serves one processor and keeps a small direct-mapped set of cache lines, each marked Invalid, Shared (read-only) or Exclusive (read/write). A processor access that hits completes locally. A miss sends a read-miss or write-miss message to the home directory and stalls the processor until the directory's data reply arrives.

The directory can also talk to the block. It can invalidate a shared copy. It can fetch an owned line, which makes the controller write the line back and keep a shared copy. It can fetch-and-invalidate, which makes the controller write the line back and drop it. When a miss would evict an Exclusive line holding a different address, the controller first writes the dirty line back and then sends the new miss.

Messages in each direction are one-cycle pulses with no flow control. The directory must send them in order and one at a time.

Top module: `coh_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, and the first processor access to any address produces a miss message.
- R2: A read to a line that is not held sends a message of type 0 (read miss) carrying the node number and the full address. When the reply arrives, the reply data is returned and the line becomes Shared.
- R3: A write to a line that is Invalid, or held only Shared, sends a message of type 1 (write miss). When the reply arrives, the processor data replaces the line data and the line becomes Exclusive.
- R4: A read hit on a Shared or Exclusive line, or a write hit on an Exclusive line, raises the done pulse one cycle after the request with no outgoing message.
- R5: An incoming type 0 (invalidate) for a Shared line makes it Invalid.
- R6: An incoming type 1 (fetch) for an Exclusive line sends a type 2 (write-back) message with the line's address and data one cycle later, and leaves the line Shared.
- R7: An incoming type 2 (fetch/invalidate) for an Exclusive line sends a type 2 write-back with address and data, and leaves the line Invalid.
- R8: A miss that would replace an Exclusive line with a different tag first emits a write-back for the old address and data. The new miss message follows in the next cycle.
- R9: The stall output is high from the cycle after a miss is accepted until the cycle after the reply (incoming type 3) is sampled. In that cycle the done pulse and the read data appear.
- R10: A directory message that hits no valid line with the same tag, an invalidate to an Exclusive line, a fetch to a Shared line, and a reply while idle cause no message, no done pulse and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | One-cycle processor request, taken while stall is low |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | AW | Processor address (low bits select the line) |
| cpu_wdata_i | input | DW | Write data |
| cpu_stall_o | output | 1 | Processor must wait |
| cpu_done_o | output | 1 | Access completed this cycle |
| cpu_rdata_o | output | DW | Read data (write data echoed for writes) |
| dir_valid_i | input | 1 | Incoming directory message |
| dir_type_i | input | 2 | 0 invalidate, 1 fetch, 2 fetch/invalidate, 3 data reply |
| dir_addr_i | input | AW | Address of the directory message |
| dir_data_i | input | DW | Reply data |
| msg_valid_o | output | 1 | Outgoing message valid |
| msg_type_o | output | 2 | 0 read miss, 1 write miss, 2 write-back |
| msg_node_o | output | NW | Requesting node number |
| msg_addr_o | output | AW | Message address |
| msg_data_o | output | DW | Write-back data |

## Verification
A line in the wrong state shows at the ports on the very next access to it. An access the block wrongly treats as a hit produces a done pulse with no miss message one cycle after the request. An access wrongly treated as a miss produces an unexpected message in that same cycle. A fetch to that line produces a write-back that should not exist, or misses one that should, one cycle after the fetch. Corrupted line data shows up as a wrong write-back payload or a wrong read result at the next hit. The bench mixes seeded random operations with directed sequences, so every stored state is probed by a later access.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {LS_INV = 2'd0, LS_SHR = 2'd1, LS_EXC = 2'd2} line_st_e;
  typedef enum logic [1:0] {OM_RD_MISS = 2'd0, OM_WR_MISS = 2'd1, OM_WRITE_BACK = 2'd2} out_msg_e;
  typedef enum logic [1:0] {IM_INVAL = 2'd0, IM_FETCH = 2'd1, IM_FETCH_INV = 2'd2, IM_REPLY = 2'd3} in_msg_e;
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_MISS = 2'd1, S_WAIT = 2'd2} ctl_st_e;
endpackage

// File: rtl/coh_store.sv
module coh_store
  import coh_pkg::*;
#(
  parameter int SETS = 4,
  parameter int TW   = 6,
  parameter int DW   = 8,
  localparam int IW  = $clog2(SETS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] ra_idx_i,
  output logic [1:0]    ra_st_o,
  output logic [TW-1:0] ra_tag_o,
  output logic [DW-1:0] ra_data_o,
  input  logic [IW-1:0] rb_idx_i,
  output logic [1:0]    rb_st_o,
  output logic [TW-1:0] rb_tag_o,
  output logic [DW-1:0] rb_data_o,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [1:0]    wst_i,
  input  logic [TW-1:0] wtag_i,
  input  logic [DW-1:0] wdata_i
);
  logic [1:0]    st_all  [SETS];
  logic [TW-1:0] tag_all [SETS];
  logic [DW-1:0] dat_all [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [1:0]    st_r;
    logic [TW-1:0] tag_r;
    logic [DW-1:0] dat_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_r  <= LS_INV;
        tag_r <= '0;
        dat_r <= '0;
      end else if (we_i && widx_i == IW'(s)) begin
        st_r  <= wst_i;
        tag_r <= wtag_i;
        dat_r <= wdata_i;
      end
    end
    assign st_all[s]  = st_r;
    assign tag_all[s] = tag_r;
    assign dat_all[s] = dat_r;
  end

  assign ra_st_o   = st_all[ra_idx_i];
  assign ra_tag_o  = tag_all[ra_idx_i];
  assign ra_data_o = dat_all[ra_idx_i];
  assign rb_st_o   = st_all[rb_idx_i];
  assign rb_tag_o  = tag_all[rb_idx_i];
  assign rb_data_o = dat_all[rb_idx_i];

  // R1: only the three line states ever appear
  a_r1_state_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra_st_o != 2'd3 && rb_st_o != 2'd3);
endmodule

// File: rtl/coh_snoop_dec.sv
module coh_snoop_dec
  import coh_pkg::*;
#(
  parameter int TW = 6
) (
  input  logic [1:0]    line_st_i,
  input  logic [TW-1:0] line_tag_i,
  input  logic [TW-1:0] msg_tag_i,
  input  logic [1:0]    msg_type_i,
  output logic          upd_o,
  output logic          send_wb_o,
  output logic [1:0]    next_st_o
);
  logic match;
  assign match = (line_st_i != LS_INV) && (line_tag_i == msg_tag_i);

  always_comb begin
    upd_o     = 1'b0;
    send_wb_o = 1'b0;
    next_st_o = line_st_i;
    unique case (msg_type_i)
      IM_INVAL:     if (match && line_st_i == LS_SHR) begin
                      upd_o = 1'b1; next_st_o = LS_INV;
                    end
      IM_FETCH:     if (match && line_st_i == LS_EXC) begin
                      upd_o = 1'b1; send_wb_o = 1'b1; next_st_o = LS_SHR;
                    end
      IM_FETCH_INV: if (match && line_st_i == LS_EXC) begin
                      upd_o = 1'b1; send_wb_o = 1'b1; next_st_o = LS_INV;
                    end
      default: ;
    endcase
  end
endmodule

// File: rtl/coh_cache_ctrl.sv
module coh_cache_ctrl
  import coh_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int SETS    = 4,
  parameter int NW      = 2,
  parameter int NODE_ID = 1,
  localparam int IW     = $clog2(SETS),
  localparam int TW     = AW - IW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic          cpu_stall_o,
  output logic          cpu_done_o,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic          dir_valid_i,
  input  logic [1:0]    dir_type_i,
  input  logic [AW-1:0] dir_addr_i,
  input  logic [DW-1:0] dir_data_i,
  output logic          msg_valid_o,
  output logic [1:0]    msg_type_o,
  output logic [NW-1:0] msg_node_o,
  output logic [AW-1:0] msg_addr_o,
  output logic [DW-1:0] msg_data_o
);
  ctl_st_e st_q;
  logic          pend_q, rq_we_q;
  logic [AW-1:0] rq_addr_q;
  logic [DW-1:0] rq_wdata_q;

  logic dir_reply, dir_snoop;
  assign dir_reply = dir_valid_i && dir_type_i == IM_REPLY;
  assign dir_snoop = dir_valid_i && !dir_reply && (st_q == S_IDLE || st_q == S_WAIT);

  // request seen by the idle state: deferred one or live one
  logic          cur_we;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;
  assign cur_we    = pend_q ? rq_we_q    : cpu_we_i;
  assign cur_addr  = pend_q ? rq_addr_q  : cpu_addr_i;
  assign cur_wdata = pend_q ? rq_wdata_q : cpu_wdata_i;

  logic go;
  assign go = (st_q == S_IDLE) && (pend_q || cpu_req_i) && !dir_snoop;

  logic [IW-1:0] a_idx;
  logic [TW-1:0] a_tag_req;
  assign a_idx     = (st_q == S_IDLE) ? cur_addr[IW-1:0]  : rq_addr_q[IW-1:0];
  assign a_tag_req = (st_q == S_IDLE) ? cur_addr[AW-1:IW] : rq_addr_q[AW-1:IW];

  logic [1:0]    a_st, b_st;
  logic [TW-1:0] a_tag, b_tag;
  logic [DW-1:0] a_data, b_data;
  logic          s_we;
  logic [IW-1:0] s_widx;
  logic [1:0]    s_wst;
  logic [TW-1:0] s_wtag;
  logic [DW-1:0] s_wdata;

  coh_store #(.SETS(SETS), .TW(TW), .DW(DW)) u_store (
    .clk_i, .rst_ni,
    .ra_idx_i(a_idx), .ra_st_o(a_st), .ra_tag_o(a_tag), .ra_data_o(a_data),
    .rb_idx_i(dir_addr_i[IW-1:0]), .rb_st_o(b_st), .rb_tag_o(b_tag), .rb_data_o(b_data),
    .we_i(s_we), .widx_i(s_widx), .wst_i(s_wst), .wtag_i(s_wtag), .wdata_i(s_wdata)
  );

  logic sn_upd, sn_wb;
  logic [1:0] sn_next;
  coh_snoop_dec #(.TW(TW)) u_dec (
    .line_st_i(b_st), .line_tag_i(b_tag), .msg_tag_i(dir_addr_i[AW-1:IW]),
    .msg_type_i(dir_type_i), .upd_o(sn_upd), .send_wb_o(sn_wb), .next_st_o(sn_next)
  );

  logic tag_eq, hit, evict;
  assign tag_eq = (a_st != LS_INV) && (a_tag == a_tag_req);
  assign hit    = tag_eq && (!cur_we || a_st == LS_EXC);
  assign evict  = !hit && a_st == LS_EXC && a_tag != a_tag_req;

  // single store write port; the sources never coincide
  always_comb begin
    s_we    = 1'b0;
    s_widx  = a_idx;
    s_wst   = a_st;
    s_wtag  = a_tag;
    s_wdata = a_data;
    if (dir_snoop && sn_upd) begin
      s_we    = 1'b1;
      s_widx  = dir_addr_i[IW-1:0];
      s_wst   = sn_next;
      s_wtag  = b_tag;
      s_wdata = b_data;
    end else if (go && hit && cur_we) begin
      s_we    = 1'b1;
      s_wdata = cur_wdata;
    end else if (go && evict) begin
      s_we  = 1'b1;
      s_wst = LS_INV;
    end else if (st_q == S_WAIT && dir_reply) begin
      s_we    = 1'b1;
      s_wst   = rq_we_q ? LS_EXC : LS_SHR;
      s_wtag  = rq_addr_q[AW-1:IW];
      s_wdata = rq_we_q ? rq_wdata_q : dir_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      pend_q      <= 1'b0;
      rq_we_q     <= 1'b0;
      rq_addr_q   <= '0;
      rq_wdata_q  <= '0;
      cpu_done_o  <= 1'b0;
      cpu_rdata_o <= '0;
      msg_valid_o <= 1'b0;
      msg_type_o  <= OM_RD_MISS;
      msg_addr_o  <= '0;
      msg_data_o  <= '0;
    end else begin
      msg_valid_o <= 1'b0;
      cpu_done_o  <= 1'b0;
      if (dir_snoop && sn_wb) begin
        msg_valid_o <= 1'b1;
        msg_type_o  <= OM_WRITE_BACK;
        msg_addr_o  <= dir_addr_i;
        msg_data_o  <= b_data;
      end
      unique case (st_q)
        S_IDLE: begin
          if (cpu_req_i && dir_snoop && !pend_q) begin
            pend_q     <= 1'b1;
            rq_we_q    <= cpu_we_i;
            rq_addr_q  <= cpu_addr_i;
            rq_wdata_q <= cpu_wdata_i;
          end else if (go) begin
            pend_q     <= 1'b0;
            rq_we_q    <= cur_we;
            rq_addr_q  <= cur_addr;
            rq_wdata_q <= cur_wdata;
            if (hit) begin
              cpu_done_o  <= 1'b1;
              cpu_rdata_o <= cur_we ? cur_wdata : a_data;
            end else if (evict) begin
              msg_valid_o <= 1'b1;
              msg_type_o  <= OM_WRITE_BACK;
              msg_addr_o  <= {a_tag, a_idx};
              msg_data_o  <= a_data;
              st_q        <= S_MISS;
            end else begin
              msg_valid_o <= 1'b1;
              msg_type_o  <= cur_we ? OM_WR_MISS : OM_RD_MISS;
              msg_addr_o  <= cur_addr;
              msg_data_o  <= '0;
              st_q        <= S_WAIT;
            end
          end
        end
        S_MISS: begin
          msg_valid_o <= 1'b1;
          msg_type_o  <= rq_we_q ? OM_WR_MISS : OM_RD_MISS;
          msg_addr_o  <= rq_addr_q;
          msg_data_o  <= '0;
          st_q        <= S_WAIT;
        end
        S_WAIT: begin
          if (dir_reply) begin
            cpu_done_o  <= 1'b1;
            cpu_rdata_o <= rq_we_q ? rq_wdata_q : dir_data_i;
            st_q        <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cpu_stall_o = (st_q != S_IDLE) || pend_q;
  assign msg_node_o  = NW'(NODE_ID);

  a_r9_stall_in_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_WAIT && !dir_reply) |=> cpu_stall_o);
  a_r9_done_on_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_WAIT && dir_reply) |=> (cpu_done_o && !cpu_stall_o));
  a_r8_wb_before_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_MISS) |-> (msg_valid_o && msg_type_o == OM_WRITE_BACK));
  a_r8_miss_follows_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_MISS) |=> (msg_valid_o && msg_type_o != OM_WRITE_BACK));
  a_r4_hit_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && hit) |=> (cpu_done_o && !msg_valid_o));
endmodule

// File: tb/sim_coh_cache_ctrl.sv
module sim_coh_cache_ctrl;
  localparam int AW = 8, DW = 8, SETS = 4, NW = 2, NODE = 1;
  localparam int IW = 2, TW = AW - IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          stall, done;
  logic [DW-1:0] rdata;
  logic          dir_valid = 1'b0;
  logic [1:0]    dir_type = '0;
  logic [AW-1:0] dir_addr = '0;
  logic [DW-1:0] dir_data = '0;
  logic          mv;
  logic [1:0]    mt;
  logic [NW-1:0] mn;
  logic [AW-1:0] ma;
  logic [DW-1:0] md;

  coh_cache_ctrl #(.AW(AW), .DW(DW), .SETS(SETS), .NW(NW), .NODE_ID(NODE)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_stall_o(stall), .cpu_done_o(done), .cpu_rdata_o(rdata),
    .dir_valid_i(dir_valid), .dir_type_i(dir_type), .dir_addr_i(dir_addr), .dir_data_i(dir_data),
    .msg_valid_o(mv), .msg_type_o(mt), .msg_node_o(mn), .msg_addr_o(ma), .msg_data_o(md)
  );

  logic [1:0]    m_st [SETS];
  logic [TW-1:0] m_tg [SETS];
  logic [DW-1:0] m_dt [SETS];
  logic [DW-1:0] mem  [256];
  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    logic [IW-1:0] ix = a[IW-1:0];
    logic [TW-1:0] tg = a[AW-1:IW];
    bit hit   = m_st[ix] != 2'd0 && m_tg[ix] == tg && (!we || m_st[ix] == 2'd2);
    bit evict = !hit && m_st[ix] == 2'd2 && m_tg[ix] != tg;
    string rr = we ? "R3" : "R2";
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    if (hit) begin
      check(done == 1'b1, "R4 hit done", 32'(done), 32'd1);
      check(mv == 1'b0, "R4 hit sends nothing", 32'(mv), 32'd0);
      check(rdata == (we ? wd : m_dt[ix]), "R4 hit data", 32'(rdata), 32'(we ? wd : m_dt[ix]));
      if (we) m_dt[ix] = wd;
    end else begin
      if (evict) begin
        check(mv && mt == 2'd2, "R8 write-back first", 32'({mv, mt}), 32'h6);
        check(ma == {m_tg[ix], ix}, "R8 write-back addr", 32'(ma), 32'({m_tg[ix], ix}));
        check(md == m_dt[ix], "R8 write-back data", 32'(md), 32'(m_dt[ix]));
        mem[{m_tg[ix], ix}] = m_dt[ix];
        m_st[ix] = 2'd0;
        @(negedge clk);
      end
      check(mv && mt == (we ? 2'd1 : 2'd0), {rr, " miss type"}, 32'({mv, mt}), 32'({1'b1, (we ? 2'd1 : 2'd0)}));
      check(mn == NW'(NODE) && ma == a, {rr, " miss node/addr"}, 32'({mn, ma}), 32'({NW'(NODE), a}));
      check(stall == 1'b1, "R9 stall after miss", 32'(stall), 32'd1);
      repeat (2) begin
        @(negedge clk);
        check(stall && !done && !mv, "R9 waiting", 32'({stall, done, mv}), 32'h4);
      end
      dir_valid = 1'b1; dir_type = 2'd3; dir_addr = a; dir_data = mem[a];
      @(negedge clk);
      dir_valid = 1'b0;
      check(done && !stall, "R9 done on reply", 32'({done, stall}), 32'h2);
      check(rdata == (we ? wd : mem[a]), {rr, " returned data"}, 32'(rdata), 32'(we ? wd : mem[a]));
      m_st[ix] = we ? 2'd2 : 2'd1;
      m_tg[ix] = tg;
      m_dt[ix] = we ? wd : mem[a];
    end
  endtask

  task automatic dir_msg(input logic [1:0] t, input logic [AW-1:0] a);
    logic [IW-1:0] ix = a[IW-1:0];
    bit match = m_st[ix] != 2'd0 && m_tg[ix] == a[AW-1:IW];
    bit wb = match && m_st[ix] == 2'd2 && (t == 2'd1 || t == 2'd2);
    string rr = (t == 2'd1) ? "R6" : (t == 2'd2) ? "R7" : (t == 2'd0 && match && m_st[ix] == 2'd1) ? "R5" : "R10";
    @(negedge clk);
    dir_valid = 1'b1; dir_type = t; dir_addr = a; dir_data = 8'hEE;
    @(negedge clk);
    dir_valid = 1'b0;
    check(done == 1'b0, {rr, " no done"}, 32'(done), 32'd0);
    if (wb) begin
      check(mv && mt == 2'd2, {rr, " write-back sent"}, 32'({mv, mt}), 32'h6);
      check(ma == a && md == m_dt[ix], {rr, " write-back payload"}, 32'({ma, md}), 32'({a, m_dt[ix]}));
      mem[a] = m_dt[ix];
      m_st[ix] = (t == 2'd1) ? 2'd1 : 2'd0;
    end else begin
      check(mv == 1'b0, {rr, " no message"}, 32'(mv), 32'd0);
      if (t == 2'd0 && match && m_st[ix] == 2'd1) m_st[ix] = 2'd0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    wrap_up();
  end

  initial begin
    logic [AW-1:0] a1, a2;
    int unused_seed;
    unused_seed = $urandom(32'h5EED);
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    for (int i = 0; i < SETS; i++) begin m_st[i] = 2'd0; m_tg[i] = '0; m_dt[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!stall && !done && !mv, "R1 reset outputs", 32'({stall, done, mv}), 32'd0);

    a1 = 8'h11; a2 = 8'h21;          // same line, different tags
    cpu_op(1'b1, a1, 8'h10);         // R1/R3 write miss from Invalid
    cpu_op(1'b0, a1, 8'h00);         // R4 read hit on Exclusive
    dir_msg(2'd1, a1);               // R6 fetch: write-back, Shared
    cpu_op(1'b0, a1, 8'h00);         // R4 read hit on Shared
    cpu_op(1'b1, a1, 8'h20);         // R3 write miss from Shared, no write-back
    cpu_op(1'b1, a2, 8'h40);         // R8 evict owned line first
    dir_msg(2'd2, a2);               // R7 fetch/invalidate
    cpu_op(1'b0, a2, 8'h00);         // R2 read miss returns written-back value
    dir_msg(2'd0, a2);               // R5 invalidate Shared
    cpu_op(1'b0, a2, 8'h00);         // R5 line now misses again
    dir_msg(2'd1, 8'h31);            // R10 fetch to absent tag
    cpu_op(1'b1, a2, 8'h77);
    dir_msg(2'd0, a2);               // R10 invalidate on Exclusive ignored
    cpu_op(1'b1, a2, 8'h78);         // still a hit
    dir_msg(2'd3, a2);               // R10 stray reply while idle
    dir_msg(2'd1, 8'h02);            // R10 fetch to Invalid line

    for (int i = 0; i < 400; i++) begin
      logic [TW-1:0] t6;
      logic [IW-1:0] ix;
      t6 = TW'($urandom_range(1, 3));
      ix = IW'($urandom_range(0, SETS - 1));
      if ($urandom_range(0, 9) < 7)
        cpu_op(1'($urandom_range(0, 1)), {t6, ix}, 8'($urandom));
      else
        dir_msg(2'($urandom_range(0, 2)), {t6, ix});
    end
    repeat (2) @(negedge clk);
    wrap_up();
  end
endmodule